// File: doc/BRIEF.md
# Read Burst Interruption Monitor

This block watches a DDR2-style command bus one command per clock and reports when a read burst is cut short in a way the memory does not allow, or when a precharge arrives too soon after a read. It never drives the bus. It is placed beside a memory controller or a bus model, and its flag and code are used for debug and for checks in simulation or in silicon.

The monitor follows the most recent accepted read. From that read it knows the burst window (half the mode-register burst length, in clocks) and the read-to-precharge distance (additive latency plus half the burst length). A read may cut into a running burst only when the mode register selects bursts of eight, only when the running burst came from a read without auto precharge, and only exactly two clocks after that read. The bank of the cutting read does not matter. A cutting read with auto precharge is legal. After a legal cut, every distance is measured again from the new read, always with the full mode-register burst length.

Tracking is a three-state machine. `ST_IDLE` means no read needs guarding. `ST_PLAIN` means the last accepted read had no auto precharge. `ST_AUTO` means it had auto precharge. An accepted read moves any state to `ST_PLAIN` or `ST_AUTO` according to its kind and restarts the clock count at one. In `ST_PLAIN` or `ST_AUTO`, once the count reaches the read-to-precharge distance with no new read, the machine returns to `ST_IDLE`. A command that breaks a rule changes no tracking state.

Top module: `rd_intr_monitor`

## Requirements
- R1: After reset the flag and the code are 0 and no read is tracked, so a precharge issued straight after reset is legal. A reset in the middle of a burst also clears the tracked read.
- R2: The command bus uses the encoding 0 = no operation, 1 = read, 2 = read with auto precharge, 3 = write, 4 = precharge. Other values act as no operation. The flag and the code are registered. They show the result of a command in the clock after that command and last one clock. The flag is 1 exactly when the code is not 0.
- R3: With bursts of four selected (`burst8_i` = 0), a read of either kind one clock after the tracked read gives code 1. This check comes before R7.
- R4: With bursts of eight, a read of either kind to any bank exactly two clocks after a tracked read without auto precharge is legal. It gives code 0 and becomes the tracked read.
- R5: With bursts of eight and a tracked read without auto precharge, a read one or three clocks after it gives code 3.
- R6: A write or a precharge, to any bank, that comes less than half the burst length after the tracked read gives code 2.
- R7: With bursts of eight, any read that comes less than four clocks after a tracked read with auto precharge gives code 4.
- R8: A precharge to the bank of the tracked read gives code 5 when it comes at least half the burst length after that read but less than the additive latency plus half the burst length. At or beyond that distance it is legal. A precharge to another bank past the burst window is legal.
- R9: A read that comes half the burst length or more after the tracked read is legal and becomes the new tracked read.
- R10: A command that breaks a rule does not change what is tracked. After a read rejected one clock after a tracked read, a read two clocks after that same tracked read is still legal.
- R11: After a legal cut, the precharge distance is measured from the cutting read, using the full mode-register burst length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_i | input | 3 | Command in this clock (encoding in R2) |
| bank_i | input | BANK_W | Bank addressed by the command |
| burst8_i | input | 1 | Mode-register burst length: 1 = eight, 0 = four |
| add_lat_i | input | AL_W | Mode-register additive latency in clocks |
| viol_o | output | 1 | Rule broken by the previous command |
| err_code_o | output | 3 | Code of the rule broken (0 to 5) |

## Verification
The assertions and the priority order assume that the burst-length and additive-latency inputs hold steady while a read is tracked, because both distances are worked out from their current values. The stimulus changes these mode inputs only after a gap of no-operation commands that is longer than the largest precharge distance in use, so the monitor is back in `ST_IDLE` before any change. Each scenario starts from one accepted read and places a single second command at each offset from one clock up to one past the precharge distance. Every second command, every filler command and every gap command is checked against codes that the bench works out from the rules.

// File: rtl/rim_pkg.sv
package rim_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_RD  = 3'd1,
        CMD_RDA = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4
    } cmd_e;

    typedef enum logic [2:0] {
        ERR_NONE     = 3'd0,
        ERR_BL4      = 3'd1,
        ERR_NOTRD    = 3'd2,
        ERR_OFFSET   = 3'd3,
        ERR_AUTOPRE  = 3'd4,
        ERR_EARLYPRE = 3'd5
    } err_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PLAIN = 2'd1,
        ST_AUTO  = 2'd2
    } trk_state_e;

    localparam int unsigned CUT_OFFSET = 2;

endpackage

// File: rtl/rim_burst_tracker.sv
module rim_burst_tracker
    import rim_pkg::*;
#(
    parameter int unsigned BANK_W = 3,
    parameter int unsigned CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_rd,
    input  logic              acc_auto,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic [CNT_W-1:0]  pre_lim,
    output trk_state_e        st,
    output logic [CNT_W-1:0]  since_rd,
    output logic [BANK_W-1:0] trk_bank
);

    trk_state_e        st_nx;
    logic [CNT_W-1:0]  cnt_nx;
    logic [BANK_W-1:0] bank_nx;
    logic [CNT_W:0]    cnt_inc;

    assign cnt_inc = {1'b0, since_rd} + {{CNT_W{1'b0}}, 1'b1};

    always_comb begin
        st_nx   = st;
        cnt_nx  = since_rd;
        bank_nx = trk_bank;
        if (acc_rd) begin
            st_nx   = acc_auto ? ST_AUTO : ST_PLAIN;
            cnt_nx  = {{(CNT_W-1){1'b0}}, 1'b1};
            bank_nx = rd_bank;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    st_nx = ST_IDLE;
                end
                ST_PLAIN, ST_AUTO: begin
                    if (cnt_inc >= {1'b0, pre_lim}) begin
                        st_nx = ST_IDLE;
                    end
                    if (since_rd != {CNT_W{1'b1}}) begin
                        cnt_nx = cnt_inc[CNT_W-1:0];
                    end
                end
                default: st_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            since_rd <= '0;
            trk_bank <= '0;
        end else begin
            st       <= st_nx;
            since_rd <= cnt_nx;
            trk_bank <= bank_nx;
        end
    end

    // R9
    idle_rd_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && acc_rd) |=> (st != ST_IDLE));

endmodule

// File: rtl/rim_rule_check.sv
module rim_rule_check
    import rim_pkg::*;
#(
    parameter int unsigned BANK_W = 3,
    parameter int unsigned CNT_W  = 4
) (
    input  logic [2:0]        cmd_raw,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic              burst8,
    input  logic [CNT_W-1:0]  win_len,
    input  logic [CNT_W-1:0]  pre_lim,
    input  trk_state_e        st,
    input  logic [CNT_W-1:0]  since_rd,
    input  logic [BANK_W-1:0] trk_bank,
    output err_e              code,
    output logic              acc_rd,
    output logic              acc_auto
);

    cmd_e cmd;
    logic is_rd;
    logic in_win;
    logic in_pre;

    assign cmd    = cmd_e'(cmd_raw);
    assign is_rd  = (cmd == CMD_RD) || (cmd == CMD_RDA);
    assign in_win = (st != ST_IDLE) && (since_rd < win_len);
    assign in_pre = (st != ST_IDLE) && (since_rd < pre_lim);

    always_comb begin
        code = ERR_NONE;
        unique case (cmd)
            CMD_RD, CMD_RDA: begin
                if (in_win) begin
                    if (!burst8) begin
                        code = ERR_BL4;
                    end else if (st == ST_AUTO) begin
                        code = ERR_AUTOPRE;
                    end else if (since_rd != CNT_W'(CUT_OFFSET)) begin
                        code = ERR_OFFSET;
                    end
                end
            end
            CMD_WR: begin
                if (in_win) begin
                    code = ERR_NOTRD;
                end
            end
            CMD_PRE: begin
                if (in_win) begin
                    code = ERR_NOTRD;
                end else if (in_pre && (cmd_bank == trk_bank)) begin
                    code = ERR_EARLYPRE;
                end
            end
            default: code = ERR_NONE;
        endcase
    end

    assign acc_rd   = is_rd && (code == ERR_NONE);
    assign acc_auto = (cmd == CMD_RDA);

endmodule

// File: rtl/rd_intr_monitor.sv
module rd_intr_monitor
    import rim_pkg::*;
#(
    parameter int unsigned BANK_W = 3,
    parameter int unsigned AL_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cmd_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic              burst8_i,
    input  logic [AL_W-1:0]   add_lat_i,
    output logic              viol_o,
    output logic [2:0]        err_code_o
);

    localparam int unsigned MAX_PRE = (2 ** AL_W) - 1 + 4;
    localparam int unsigned CNT_W   = $clog2(MAX_PRE + 1);

    logic [CNT_W-1:0]  win_len;
    logic [CNT_W-1:0]  pre_lim;
    trk_state_e        st;
    logic [CNT_W-1:0]  since_rd;
    logic [BANK_W-1:0] trk_bank;
    err_e              code;
    logic              acc_rd;
    logic              acc_auto;

    assign win_len = burst8_i ? CNT_W'(4) : CNT_W'(2);
    assign pre_lim = CNT_W'(add_lat_i) + win_len;

    rim_rule_check #(
        .BANK_W (BANK_W),
        .CNT_W  (CNT_W)
    ) u_rule (
        .cmd_raw  (cmd_i),
        .cmd_bank (bank_i),
        .burst8   (burst8_i),
        .win_len  (win_len),
        .pre_lim  (pre_lim),
        .st       (st),
        .since_rd (since_rd),
        .trk_bank (trk_bank),
        .code     (code),
        .acc_rd   (acc_rd),
        .acc_auto (acc_auto)
    );

    rim_burst_tracker #(
        .BANK_W (BANK_W),
        .CNT_W  (CNT_W)
    ) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_rd   (acc_rd),
        .acc_auto (acc_auto),
        .rd_bank  (bank_i),
        .pre_lim  (pre_lim),
        .st       (st),
        .since_rd (since_rd),
        .trk_bank (trk_bank)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol_o     <= 1'b0;
            err_code_o <= ERR_NONE;
        end else begin
            viol_o     <= (code != ERR_NONE);
            err_code_o <= code;
        end
    end

    // R3
    bl4_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst8_i && st != ST_IDLE && since_rd == CNT_W'(1)
         && (cmd_i == CMD_RD || cmd_i == CMD_RDA))
        |=> (viol_o && err_code_o == ERR_BL4));

    // R4
    legal_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst8_i && st == ST_PLAIN && since_rd == CNT_W'(2)
         && (cmd_i == CMD_RD || cmd_i == CMD_RDA))
        |=> (!viol_o && st != ST_IDLE && since_rd == CNT_W'(1)));

    // R6
    non_read_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_i == CMD_WR || cmd_i == CMD_PRE) && st != ST_IDLE && since_rd < win_len)
        |=> (viol_o && err_code_o == ERR_NOTRD));

    // R7
    auto_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst8_i && st == ST_AUTO && since_rd < CNT_W'(4)
         && (cmd_i == CMD_RD || cmd_i == CMD_RDA))
        |=> (viol_o && err_code_o == ERR_AUTOPRE));

    // R8
    early_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_PRE && st != ST_IDLE && since_rd >= win_len
         && since_rd < pre_lim && bank_i == trk_bank)
        |=> (viol_o && err_code_o == ERR_EARLYPRE));

    // R2
    flag_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_NOP) |=> (!viol_o && err_code_o == ERR_NONE));

endmodule

// File: tb/sim_rd_intr_monitor.sv
`timescale 1ns/1ps
module sim_rd_intr_monitor;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cmd = 3'd0;
    logic [2:0] bank = 3'd0;
    logic       bl8 = 1'b1;
    logic [2:0] al = 3'd0;
    logic       viol;
    logic [2:0] err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rd_intr_monitor #(.BANK_W(3), .AL_W(3)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_i      (cmd),
        .bank_i     (bank),
        .burst8_i   (bl8),
        .add_lat_i  (al),
        .viol_o     (viol),
        .err_code_o (err)
    );

    task automatic chk(input int exp, input string tag);
        n_chk++;
        if (viol !== (exp != 0) || err !== exp[2:0]) begin
            n_fail++;
            $display("FAIL %s: flag=%0b code=%0d, expected flag=%0b code=%0d",
                     tag, viol, err, (exp != 0), exp);
        end
    endtask

    task automatic step(input logic [2:0] c, input logic [2:0] b, input int exp, input string tag);
        cmd  = c;
        bank = b;
        @(negedge clk);
        chk(exp, tag);
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) step(3'd0, 3'd0, 0, "R2 idle");
    endtask

    function automatic int exp_code(input bit b8, input int lat, input bit first_auto,
                                    input int d, input int c, input bit same);
        int win = b8 ? 4 : 2;
        int pre = lat + win;
        if (c == 1 || c == 2) begin
            if (d < win) begin
                if (!b8) return 1;
                if (first_auto) return 4;
                if (d != 2) return 3;
            end
            return 0;
        end
        if (c == 3) return (d < win) ? 2 : 0;
        if (c == 4) begin
            if (d < win) return 2;
            if (same && d < pre) return 5;
        end
        return 0;
    endfunction

    function automatic string tag_of(input int code);
        case (code)
            1: return "R3";
            2: return "R6";
            3: return "R5";
            4: return "R7";
            5: return "R8";
            default: return "R4/R9";
        endcase
    endfunction

    initial begin
        int wd = 0;
        while (!done) begin
            @(posedge clk);
            wd++;
            if (wd > 150000) begin
                n_fail++;
                $display("FAIL watchdog: cycles=%0d, expected below 150000", wd);
                $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
                $finish;
            end
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(0, "R1 reset");
        rst_n = 1'b1;
        step(3'd4, 3'd2, 0, "R1 precharge after reset");
        gap(2);

        // R1 reset in mid burst clears tracking
        bl8 = 1'b1; al = 3'd2;
        step(3'd1, 3'd2, 0, "R1 first read");
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        step(3'd4, 3'd2, 0, "R1 precharge after mid-burst reset");
        gap(12);

        // Sweep: mode x first kind x offset x second command
        for (int m8 = 0; m8 < 2; m8++) begin
            for (int lat = 0; lat < 4; lat++) begin
                for (int fa = 0; fa < 2; fa++) begin
                    for (int c2 = 1; c2 <= 5; c2++) begin
                        int win = (m8 != 0) ? 4 : 2;
                        for (int d = 1; d <= lat + win + 1; d++) begin
                            int cc = (c2 == 5) ? 4 : c2;
                            bit same = (c2 == 4);
                            logic [2:0] b2;
                            int e;
                            bl8 = (m8 != 0);
                            al  = 3'(lat);
                            b2  = same ? 3'd3 : 3'd6;
                            e   = exp_code(m8 != 0, lat, fa != 0, d, cc, same);
                            step((fa != 0) ? 3'd2 : 3'd1, 3'd3, 0, "R9 first read");
                            for (int k = 1; k < d; k++) step(3'd0, 3'd0, 0, "R2 filler");
                            step(3'(cc), b2, e, tag_of(e));
                            gap(12);
                        end
                    end
                end
            end
        end

        // R10: rejected read keeps reference on original read
        bl8 = 1'b1; al = 3'd2;
        step(3'd1, 3'd1, 0, "R10 first read");
        step(3'd1, 3'd1, 3, "R10 rejected read at 1");
        step(3'd1, 3'd5, 0, "R10 read at 2 from original");
        // R11: precharge distance from cutting read (bank 5), AL=2, BL8 -> 6
        step(3'd0, 3'd0, 0, "R11 filler");
        step(3'd0, 3'd0, 0, "R11 filler");
        step(3'd0, 3'd0, 0, "R11 filler");
        step(3'd4, 3'd5, 5, "R11 precharge at 4");
        step(3'd4, 3'd5, 5, "R11 precharge at 5");
        step(3'd4, 3'd5, 0, "R11 precharge at 6");
        step(3'd0, 3'd0, 0, "R2 pulse ends");
        gap(12);

        // R9: late read restarts window measured from itself
        step(3'd1, 3'd4, 0, "R9 read");
        gap(3);
        step(3'd1, 3'd4, 0, "R9 read at 4");
        step(3'd3, 3'd4, 2, "R9 write at 1 of new burst");
        step(3'd0, 3'd0, 0, "R2 pulse ends");
        gap(12);

        // R2: unused encodings act as no operation
        step(3'd1, 3'd0, 0, "R2 read");
        step(3'd7, 3'd0, 0, "R2 unused code");
        step(3'd1, 3'd0, 0, "R2 read at 2 still legal");
        gap(12);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule